// File: doc/BRIEF.md
# Flash write and erase sequencer

This block is a host-side engine that drives a serial NOR flash over a four-wire SPI link in clock mode 0. A host hands it one request at a time. A request is either a page write of 1 to 256 bytes, taken from a small local byte buffer, or an erase whose scope is a 4 KB sector, a block or the whole chip. The engine then runs the full sequence on its own. It sends a one-byte write-enable transaction, then the program or erase command, and then status reads until the device reports that it is no longer busy. It ends each request with exactly one result pulse: finished, timed out or rejected.

The host loads page data through a byte stream before it issues the request. Both the byte stream and the request port are valid/ready. A byte or a request is taken on a clock edge only when valid and ready are both high. The host must hold valid and the payload steady until that edge. Ready is low whenever the engine is executing, so the host is held off for the whole duration of an operation. The byte stream also stalls when the buffer is full. The buffer empties after every page-write request ends, whatever the result. A page write whose range would run past the end of a 256-byte page is refused before any bus activity.

Top module: `flash_prog_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, chip select is high, the serial clock is low, `req_ready` is high, `busy` is low and none of `done`, `timeout` or `err` is high.
- R2: Every accepted request starts with its own transaction that carries exactly one byte, 0x06 (write enable). Chip select is low for that byte only.
- R3: The second transaction holds the command. For a page write it is 0x02, then the 24-bit address with the most significant byte first, then `req_len` buffer bytes in the order they were loaded. Sector erase (`req_op`=1) sends 0x20 and block erase (`req_op`=2) sends 0xD8, each followed by the three address bytes. Chip erase (`req_op`=3) sends 0xC7 alone. Page write is `req_op`=0.
- R4: After the command, the engine repeats a two-byte transaction: it sends 0x05 and then reads one byte. Bit 0 of that byte is the busy flag. When a read returns bit 0 clear, the engine pulses `done` and issues no further transaction.
- R5: If `poll_limit` consecutive reads all return bit 0 set, the engine pulses `timeout` and stops. A `poll_limit` of 0 acts as 1.
- R6: A request whose last permitted read returns bit 0 clear ends with `done` and never with `timeout`.
- R7: The serial clock is low whenever chip select is high. Each bit lasts `CLK_DIV` system clocks and the clock is high for `CLK_DIV/2` of them. `spi_mosi` changes only while the clock is low, and bits go out most significant first.
- R8: Between any two transactions, chip select stays high for at least two system clocks.
- R9: A page write is refused with a one-cycle `err` pulse and no chip-select activity in four cases: the length is 0, it exceeds 256, it exceeds the number of bytes loaded, or the low 8 address bits plus the length exceed 256.
- R10: `req_ready` is high only while the engine is idle. `wr_ready` is high only while the engine is idle and the buffer holds fewer than 256 bytes. After a page-write request ends, the buffer is empty.
- R11: Each accepted request produces exactly one pulse, one cycle long, on exactly one of `done`, `timeout` and `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle; request taken when both high |
| req_op | input | 2 | 0 page write, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | 24 | Flash byte address |
| req_len | input | 9 | Page write length in bytes |
| poll_limit | input | 16 | Maximum number of status reads |
| wr_valid | input | 1 | Buffer byte offered |
| wr_ready | output | 1 | Buffer accepts a byte |
| wr_data | input | 8 | Buffer byte |
| busy | output | 1 | A request is executing |
| done | output | 1 | Request finished (pulse) |
| timeout | output | 1 | Poll limit reached while busy (pulse) |
| err | output | 1 | Page write refused (pulse) |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Data to the flash |
| spi_miso | input | 1 | Data from the flash |

## Verification
The two outcomes that can coincide are the busy flag clearing and the poll budget running out. Both are decided on the very same status read when the flash stays busy for exactly one read fewer than `poll_limit`. The bench's flash model is set up to hit that case. The outcome is judged correct when a lone `done` pulse appears with exactly `poll_limit` status transactions logged. A neighbouring row, where the flash stays busy for as many reads as the limit, must give `timeout` instead.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [1:0] {
    OP_PAGE = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } fps_op_e;

  typedef enum logic [1:0] {
    TX_WREN = 2'd0,
    TX_CMD  = 2'd1,
    TX_POLL = 2'd2
  } fps_txn_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } fps_state_e;

  localparam logic [7:0] CMD_WREN  = 8'h06;
  localparam logic [7:0] CMD_PROG  = 8'h02;
  localparam logic [7:0] CMD_SECT  = 8'h20;
  localparam logic [7:0] CMD_BLK   = 8'hD8;
  localparam logic [7:0] CMD_CHIP  = 8'hC7;
  localparam logic [7:0] CMD_RDSR  = 8'h05;
  localparam logic [7:0] POLL_MASK = 8'h01;
endpackage

// File: rtl/fps_spi_shift.sv
module fps_spi_shift #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi
);
  localparam int HI_CYC = CLK_DIV / 2;
  localparam int LO_CYC = CLK_DIV - HI_CYC;
  localparam int CW     = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] RISE_AT = CW'(LO_CYC - 1);
  localparam logic [CW-1:0] FALL_AT = CW'(CLK_DIV - 1);

  logic          act;
  logic [CW-1:0] cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    sh_tx;
  logic [7:0]    sh_rx;

  assign rx_byte = sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      cnt     <= '0;
      bit_idx <= '0;
      sh_tx   <= '0;
      sh_rx   <= '0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!act) begin
        if (start) begin
          act     <= 1'b1;
          cnt     <= '0;
          bit_idx <= '0;
          sh_tx   <= tx_byte;
          mosi    <= tx_byte[7];
        end
      end else if (cnt == RISE_AT) begin
        // rising edge: the flash holds its bit steady here
        sck   <= 1'b1;
        sh_rx <= {sh_rx[6:0], miso};
        cnt   <= cnt + CW'(1);
      end else if (cnt == FALL_AT) begin
        sck <= 1'b0;
        cnt <= '0;
        if (bit_idx == 3'd7) begin
          act  <= 1'b0;
          done <= 1'b1;
        end else begin
          bit_idx <= bit_idx + 3'd1;
          sh_tx   <= {sh_tx[6:0], 1'b0};
          mosi    <= sh_tx[6];
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/fps_page_buf.sv
module fps_page_buf #(
  parameter int DEPTH = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         allow,
  input  logic                         clr,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic [7:0]                   wr_data,
  output logic [$clog2(DEPTH+1)-1:0]   fill,
  input  logic [$clog2(DEPTH)-1:0]     rd_idx,
  output logic [7:0]                   rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int FW = $clog2(DEPTH + 1);

  logic [7:0] mem [DEPTH];
  logic       wr_fire;

  assign wr_ready = allow && (fill < FW'(DEPTH));
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_data  = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[fill[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fill <= '0;
    else if (clr)     fill <= '0;
    else if (wr_fire) fill <= fill + FW'(1);
  end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int CLK_DIV    = 4,
  parameter int PAGE_BYTES = 256,
  parameter int GAP_CYC    = 2,
  parameter int LIM_W      = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [1:0]                        req_op,
  input  logic [23:0]                       req_addr,
  input  logic [$clog2(PAGE_BYTES+1)-1:0]   req_len,
  input  logic [LIM_W-1:0]                  poll_limit,
  input  logic                              wr_valid,
  output logic                              wr_ready,
  input  logic [7:0]                        wr_data,
  output logic                              busy,
  output logic                              done,
  output logic                              timeout,
  output logic                              err,
  output logic                              spi_cs_n,
  output logic                              spi_sck,
  output logic                              spi_mosi,
  input  logic                              spi_miso
);
  import fps_pkg::*;

  localparam int LW = $clog2(PAGE_BYTES + 1);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int IW = $clog2(PAGE_BYTES + 5);
  localparam int GW = $clog2(GAP_CYC + 1);

  fps_state_e          state;
  fps_txn_e            kind;
  fps_op_e             op_q;
  logic [23:0]         addr_q;
  logic [LW-1:0]       len_q;
  logic [LIM_W-1:0]    lim_q;
  logic [LIM_W-1:0]    poll_cnt;
  logic [IW-1:0]       idx;
  logic [IW-1:0]       last_idx;
  logic [GW-1:0]       gcnt;
  logic                launch;
  logic                still_busy;
  logic                wipe;
  logic [LW-1:0]       fill;
  logic [7:0]          buf_rd;
  logic [7:0]          tx_byte;
  logic                sh_done;
  logic [7:0]          sh_rx;
  logic [LW:0]         off_ext;
  logic [LW:0]         len_ext;
  logic [LW:0]         span;
  logic                len_ok;
  logic [LIM_W:0]      poll_next;

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);

  // page-write admission: length range, loaded bytes, page boundary
  assign off_ext = (LW+1)'(req_addr[PW-1:0]);
  assign len_ext = (LW+1)'(req_len);
  assign span    = off_ext + len_ext;
  assign len_ok  = (req_len != '0) &&
                   (len_ext <= (LW+1)'(PAGE_BYTES)) &&
                   (span    <= (LW+1)'(PAGE_BYTES)) &&
                   (len_ext <= (LW+1)'(fill));

  assign poll_next = (LIM_W+1)'(poll_cnt) + (LIM_W+1)'(1);

  function automatic logic [7:0] opcode_of(fps_op_e op);
    case (op)
      OP_PAGE: return CMD_PROG;
      OP_SECT: return CMD_SECT;
      OP_BLK:  return CMD_BLK;
      default: return CMD_CHIP;
    endcase
  endfunction

  always_comb begin
    case (kind)
      TX_WREN: last_idx = '0;
      TX_POLL: last_idx = IW'(1);
      default: begin
        case (op_q)
          OP_PAGE: last_idx = IW'(len_q) + IW'(3);
          OP_CHIP: last_idx = '0;
          default: last_idx = IW'(3);
        endcase
      end
    endcase
  end

  always_comb begin
    tx_byte = 8'h00;
    case (kind)
      TX_WREN: tx_byte = CMD_WREN;
      TX_POLL: tx_byte = (idx == '0) ? CMD_RDSR : 8'h00;
      default: begin
        if (idx == IW'(0))      tx_byte = opcode_of(op_q);
        else if (idx == IW'(1)) tx_byte = addr_q[23:16];
        else if (idx == IW'(2)) tx_byte = addr_q[15:8];
        else if (idx == IW'(3)) tx_byte = addr_q[7:0];
        else                    tx_byte = buf_rd;
      end
    endcase
  end

  fps_page_buf #(.DEPTH(PAGE_BYTES)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .allow    (state == ST_IDLE),
    .clr      (wipe),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_data  (wr_data),
    .fill     (fill),
    .rd_idx   (PW'(idx - IW'(4))),
    .rd_data  (buf_rd)
  );

  fps_spi_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (launch),
    .tx_byte (tx_byte),
    .miso    (spi_miso),
    .done    (sh_done),
    .rx_byte (sh_rx),
    .sck     (spi_sck),
    .mosi    (spi_mosi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kind       <= TX_WREN;
      op_q       <= OP_PAGE;
      addr_q     <= '0;
      len_q      <= '0;
      lim_q      <= '0;
      poll_cnt   <= '0;
      idx        <= '0;
      gcnt       <= '0;
      launch     <= 1'b0;
      still_busy <= 1'b0;
      wipe       <= 1'b0;
      done       <= 1'b0;
      timeout    <= 1'b0;
      err        <= 1'b0;
      spi_cs_n   <= 1'b1;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      err     <= 1'b0;
      wipe    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (fps_op_e'(req_op) == OP_PAGE && !len_ok) begin
              err  <= 1'b1;
              wipe <= 1'b1;
            end else begin
              op_q     <= fps_op_e'(req_op);
              addr_q   <= req_addr;
              len_q    <= req_len;
              lim_q    <= (poll_limit == '0) ? LIM_W'(1) : poll_limit;
              kind     <= TX_WREN;
              idx      <= '0;
              launch   <= 1'b1;
              spi_cs_n <= 1'b0;
              state    <= ST_XFER;
            end
          end
        end
        ST_XFER: begin
          launch <= 1'b0;
          if (sh_done) begin
            if (idx == last_idx) begin
              spi_cs_n <= 1'b1;
              gcnt     <= '0;
              state    <= ST_GAP;
              if (kind == TX_POLL) still_busy <= |(sh_rx & POLL_MASK);
            end else begin
              idx    <= idx + IW'(1);
              launch <= 1'b1;
            end
          end
        end
        default: begin
          if (gcnt != GW'(GAP_CYC - 1)) begin
            gcnt <= gcnt + GW'(1);
          end else begin
            case (kind)
              TX_WREN: begin
                kind     <= TX_CMD;
                idx      <= '0;
                launch   <= 1'b1;
                spi_cs_n <= 1'b0;
                state    <= ST_XFER;
              end
              TX_CMD: begin
                kind     <= TX_POLL;
                poll_cnt <= '0;
                idx      <= '0;
                launch   <= 1'b1;
                spi_cs_n <= 1'b0;
                state    <= ST_XFER;
              end
              default: begin
                if (!still_busy) begin
                  done  <= 1'b1;
                  wipe  <= (op_q == OP_PAGE);
                  state <= ST_IDLE;
                end else if (poll_next >= (LIM_W+1)'(lim_q)) begin
                  timeout <= 1'b1;
                  wipe    <= (op_q == OP_PAGE);
                  state   <= ST_IDLE;
                end else begin
                  poll_cnt <= poll_cnt + LIM_W'(1);
                  idx      <= '0;
                  launch   <= 1'b1;
                  spi_cs_n <= 1'b0;
                  state    <= ST_XFER;
                end
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic timeout,
  input logic err,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi
);
  logic [1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hi_run <= 2'd3;
    else if (!spi_cs_n)                 hi_run <= 2'd0;
    else if (hi_run != 2'd3)            hi_run <= hi_run + 2'd1;
  end

  assert_sck_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_run >= 2'd2));

  assert_one_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, timeout, err}) <= 1);

  assert_result_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout || err) |=> !(done || timeout || err));

  assert_accept_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy || err));

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_reject_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> spi_cs_n);
endmodule

bind flash_prog_seq flash_prog_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .timeout   (timeout),
  .err       (err),
  .spi_cs_n  (spi_cs_n),
  .spi_sck   (spi_sck),
  .spi_mosi  (spi_mosi)
);

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int PAGE       = 256;
  localparam int GAP        = 2;

  typedef struct packed {
    logic [1:0]  op;
    logic [23:0] addr;
    logic [8:0]  len;
    logic [8:0]  nfill;
    logic [7:0]  nbusy;
    logic [15:0] lim;
    logic [1:0]  expr;   // 0 done, 1 timeout, 2 err
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 24'h012300, 9'd4,   9'd4,   8'd2, 16'd10, 2'd0},
    '{2'd1, 24'h045000, 9'd0,   9'd0,   8'd0, 16'd5,  2'd0},
    '{2'd2, 24'h0A0000, 9'd0,   9'd0,   8'd3, 16'd3,  2'd1},
    '{2'd3, 24'h000000, 9'd0,   9'd0,   8'd1, 16'd8,  2'd0},
    '{2'd0, 24'h0000F0, 9'd16,  9'd16,  8'd0, 16'd4,  2'd0},
    '{2'd0, 24'h0000F1, 9'd16,  9'd16,  8'd0, 16'd4,  2'd2},
    '{2'd0, 24'h007F00, 9'd256, 9'd256, 8'd1, 16'd4,  2'd0},
    '{2'd0, 24'h1000FE, 9'd2,   9'd2,   8'd2, 16'd3,  2'd0},
    '{2'd0, 24'h000010, 9'd0,   9'd0,   8'd0, 16'd4,  2'd2},
    '{2'd0, 24'h000000, 9'd4,   9'd2,   8'd0, 16'd4,  2'd2},
    '{2'd1, 24'h001000, 9'd0,   9'd0,   8'd4, 16'd0,  2'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [23:0] req_addr = '0;
  logic [8:0]  req_len = '0;
  logic [15:0] poll_limit = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = '0;
  logic        busy, done, timeout, err;
  logic        spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_seq #(.CLK_DIV(DIV), .PAGE_BYTES(PAGE), .GAP_CYC(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .poll_limit(poll_limit),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .busy(busy), .done(done), .timeout(timeout), .err(err),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // ---------------- flash model (owns its log) ----------------
  logic [7:0] mlog [2048];
  int tr_first [256];
  int tr_len   [256];
  int tr_cnt = 0;
  int nb = 0;
  int rd_total = 0;
  int busy_until = 0;   // written by the stimulus only
  logic m_cs = 1'b1;
  logic m_sck = 1'b0;
  logic [7:0] m_sh = '0;
  logic [7:0] m_out = '0;
  int m_bits = 0;
  int m_start = 0;

  always @(spi_sck or spi_cs_n) begin
    if (spi_cs_n !== m_cs) begin
      if (!spi_cs_n) begin
        m_bits  = 0;
        m_start = nb;
      end else begin
        tr_first[tr_cnt] = m_start;
        tr_len[tr_cnt]   = nb - m_start;
        tr_cnt++;
      end
      m_cs = spi_cs_n;
    end
    if (spi_sck !== m_sck) begin
      if (!spi_cs_n && spi_sck) begin
        m_sh = {m_sh[6:0], spi_mosi};
        m_bits++;
        if (m_bits % 8 == 0) begin
          mlog[nb] = m_sh;
          nb++;
        end
      end else if (!spi_cs_n && !spi_sck) begin
        if (m_bits == 8 && mlog[m_start] == 8'h05) begin
          logic [7:0] st;
          st = (rd_total < busy_until) ? 8'hA1 : 8'hA0;
          rd_total++;
          spi_miso = st[7];
          m_out = {st[6:0], 1'b0};
        end else begin
          spi_miso = m_out[7];
          m_out = {m_out[6:0], 1'b0};
        end
      end
      m_sck = spi_sck;
    end
  end

  // ---------------- bus timing monitors ----------------
  int sck_hi_run = 0;
  int sck_bad = 0;
  int cs_hi_run = 0;
  int gap_min = 1000;
  bit cs_seen = 1'b0;

  always @(negedge clk) begin
    if (spi_sck) sck_hi_run++;
    else begin
      if (sck_hi_run != 0 && sck_hi_run != DIV/2) sck_bad++;
      sck_hi_run = 0;
    end
    if (spi_sck && spi_cs_n) sck_bad++;
    if (spi_cs_n) cs_hi_run++;
    else begin
      if (cs_seen && cs_hi_run > 0 && cs_hi_run < gap_min) gap_min = cs_hi_run;
      cs_seen = 1'b1;
      cs_hi_run = 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int v, input int k);
    return 8'((v * 37 + k * 5 + 1) & 255);
  endfunction

  task automatic load_buf(input int v, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = pat(v, k);
      while (!wr_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
    $finish;
  end

  initial begin
    // R1: reset state, while reset held and just after release
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1", "bus idle in reset", {spi_cs_n, spi_sck}, 2);
    chk(req_ready && !busy && !done && !timeout && !err, "R1", "control in reset",
        {req_ready, busy, done, timeout, err}, 16);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n && !spi_sck && req_ready && !busy, "R1", "after release",
        {spi_cs_n, spi_sck, req_ready, busy}, 10);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int res, pulses, waited, base, ntr, npolls, lim_eff, cmd_len, f, mism;
      logic [7:0] opc;
      string rtag;
      t = VECS[v];
      load_buf(v, int'(t.nfill));
      if (int'(t.nfill) == PAGE)
        chk(wr_ready == 1'b0, "R10", "wr_ready low when buffer full", wr_ready, 0);
      base = tr_cnt;
      busy_until = rd_total + int'(t.nbusy);

      @(negedge clk);
      req_valid  = 1'b1;
      req_op     = t.op;
      req_addr   = t.addr;
      req_len    = t.len;
      poll_limit = t.lim;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (t.expr != 2'd2)
        chk(busy && !req_ready && !wr_ready, "R10", "ports held off while busy",
            {busy, req_ready, wr_ready}, 4);

      res = 3; pulses = 0; waited = 0;
      while (res == 3 && waited < 60000) begin
        pulses += int'(done) + int'(timeout) + int'(err);
        if (done) res = 0;
        else if (timeout) res = 1;
        else if (err) res = 2;
        if (res == 3) begin
          @(negedge clk);
          waited++;
        end
      end
      repeat (3) begin
        @(negedge clk);
        pulses += int'(done) + int'(timeout) + int'(err);
      end

      if (t.expr == 2'd2) rtag = "R9";
      else if (t.expr == 2'd1) rtag = "R5";
      else if (v == 7) rtag = "R6";
      else rtag = "R4";
      chk(res == int'(t.expr), rtag, $sformatf("result of row %0d", v), res, int'(t.expr));
      chk(pulses == 1, "R11", $sformatf("result pulses row %0d", v), pulses, 1);

      ntr = tr_cnt - base;
      if (t.expr == 2'd2) begin
        chk(ntr == 0, "R9", $sformatf("no transaction on refusal row %0d", v), ntr, 0);
      end else begin
        lim_eff = (t.lim == 16'd0) ? 1 : int'(t.lim);
        npolls  = (int'(t.nbusy) < lim_eff) ? int'(t.nbusy) + 1 : lim_eff;
        chk(ntr == 2 + npolls, (t.expr == 2'd1) ? "R5" : "R4",
            $sformatf("transaction count row %0d", v), ntr, 2 + npolls);
        f = tr_first[base];
        chk(tr_len[base] == 1 && mlog[f] == 8'h06, "R2",
            $sformatf("write enable row %0d", v), int'(mlog[f]), 6);
        // R3: command transaction contents
        case (t.op)
          2'd0: begin opc = 8'h02; cmd_len = 4 + int'(t.len); end
          2'd1: begin opc = 8'h20; cmd_len = 4; end
          2'd2: begin opc = 8'hD8; cmd_len = 4; end
          default: begin opc = 8'hC7; cmd_len = 1; end
        endcase
        f = tr_first[base + 1];
        mism = 0;
        if (tr_len[base + 1] != cmd_len) mism++;
        else begin
          if (mlog[f] != opc) mism++;
          if (cmd_len > 1) begin
            if (mlog[f + 1] != t.addr[23:16]) mism++;
            if (mlog[f + 2] != t.addr[15:8])  mism++;
            if (mlog[f + 3] != t.addr[7:0])   mism++;
          end
          for (int k = 4; k < cmd_len; k++)
            if (mlog[f + k] != pat(v, k - 4)) mism++;
        end
        chk(mism == 0, "R3", $sformatf("command bytes row %0d", v), mism, 0);
        mism = 0;
        for (int p = base + 2; p < tr_cnt; p++)
          if (tr_len[p] != 2 || mlog[tr_first[p]] != 8'h05) mism++;
        chk(mism == 0, "R4", $sformatf("status reads row %0d", v), mism, 0);
      end
      if (int'(t.nfill) == PAGE)
        chk(wr_ready == 1'b1, "R10", "buffer emptied after page write", wr_ready, 1);
    end

    chk(sck_bad == 0, "R7", "clock high time and idle level", sck_bad, 0);
    chk(gap_min >= GAP, "R8", "chip select high between transactions", gap_min, GAP);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule